// File: doc/BRIEF.md
# Masked Debug Watchpoint Comparator Pair

This block watches a processor's bus on behalf of an on-chip debugger. It holds two independent comparator units. Each unit has a target value and a per-bit ignore mask for the virtual address, the data word and a small control field (access direction, access size and one external condition line). A unit reports a hit when every bit it is told to compare agrees with the live bus. A configuration bit makes the unit qualify either on data accesses (a watchpoint) or on instruction fetches (a breakpoint). The data word is compared in both cases. The address compared is the virtual address the core presents, taken before any process-based relocation.

A hit from either enabled unit on a valid bus cycle starts a halt request to the core. A small controller with three states handles the request. **ARMED** is the reset state. A hit moves it to **HALT** (transition *trigger*). In **HALT** the `halt_req` output is high. When the debug acknowledge is seen, the controller moves to **DEBUG** (transition *acknowledge*). In **DEBUG** the request is low and hits are ignored. When the acknowledge falls, the controller returns to **ARMED** (transition *resume*).

All comparator registers are loaded and read through a serial shift path. This path stands in for a data register behind the test access port.

Top module: `wp_top`

## Requirements
- R1: After reset, `halt_req` and both `unit_hit` bits are 0, the controller is in ARMED, and every register reads back as 0. Units are therefore disabled.
- R2: `unit_hit[u]` is high in the same cycle as a bus cycle that meets all of these conditions: `bus_valid` is 1, unit u is enabled, `bus_fetch` equals the unit's mode bit, and the address, data and control fields all agree with the unit's values on every unmasked bit. Otherwise `unit_hit[u]` is 0.
- R3: A mask bit of 1 means "ignore this bit". A mask of 0 means the bit must compare. Setting a bit's mask makes a mismatch on that bit harmless.
- R4: The config register's bit 1 selects the mode. A value of 0 makes a data watchpoint, which hits only when `bus_fetch`=0. A value of 1 makes a fetch breakpoint, which hits only when `bus_fetch`=1.
- R5: The data comparison applies in both modes. A breakpoint with an unmasked data mismatch does not hit.
- R6: The config register's bit 0 enables the unit. While it is 0, the unit never hits.
- R7: The `halt_req` output rises on the clock edge after a cycle in which any `unit_hit` bit is high. It stays high until `dbg_ack` is seen, and falls on the edge after that. Hits are then ignored while `dbg_ack` stays high. The controller re-arms on the edge after `dbg_ack` is seen low.
- R8: Frames are 38 bits and are shifted in on `sh_din` least significant bit first. Bits 31:0 carry the payload, bits 36:32 the register address and bit 37 the direction (1 = write, 0 = read). A register changes only on the `sh_upd` strobe. Register address = unit*8 + index. The indices are: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value, 5 control mask, 6 config.
- R9: The control field is laid out as follows: bit 0 compares with `bus_write`, bits 2:1 compare with `bus_size`, and bit 3 compares with `ext_cond[u]` (the unit's own condition line).
- R10: A read frame copies the selected register into payload bits 31:0 at the update strobe. These bits are then shifted out on `sh_dout` least significant bit first, one bit per `sh_en` cycle. Unmapped addresses (index 7, or unit 2 and 3) ignore writes and read back as 0.
- R11: The two units are independent. When both hit in one cycle, `unit_hit` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sh_en | input | 1 | Shift the serial frame by one bit |
| sh_din | input | 1 | Serial data in |
| sh_upd | input | 1 | Update strobe: write or capture the selected register |
| sh_dout | output | 1 | Serial data out (low bit of the frame) |
| bus_valid | input | 1 | Bus cycle is valid |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write access |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 32 | Virtual address from the core |
| bus_data | input | 32 | Data or instruction word |
| ext_cond | input | 2 | External condition line, one per unit |
| dbg_ack | input | 1 | Core acknowledges debug entry |
| halt_req | output | 1 | Registered halt request |
| unit_hit | output | 2 | Per-unit live match indication |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, two units and a 5-bit register address. This setting covers both unmapped unit slots (2 and 3) as well as the unused index 7. It also makes the full 38-bit frame, and each unit's own condition line, reachable through the serial path. A behavioural model holds the register contents, which it rebuilds from a queue of shifted bits, along with the controller state. The bench compares `unit_hit` and `halt_req` against this model on every clock. Directed cycles cover masked and unmasked mismatches, mode selection, disabled units, both units hitting together, un-updated frames and readback.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int CTRL_W = 4;
    localparam int CFG_W  = 2;

    typedef enum logic [2:0] {
        IDX_AVAL  = 3'd0,
        IDX_AMASK = 3'd1,
        IDX_DVAL  = 3'd2,
        IDX_DMASK = 3'd3,
        IDX_CVAL  = 3'd4,
        IDX_CMASK = 3'd5,
        IDX_CFG   = 3'd6
    } reg_idx_t;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_HALT  = 2'd1,
        ST_DEBUG = 2'd2
    } halt_st_t;

endpackage

// File: rtl/wp_regs.sv
module wp_regs
    import wp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NU  = 2,
    parameter int RAW = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sh_en,
    input  logic                         sh_din,
    input  logic                         sh_upd,
    output logic                         sh_dout,
    output logic [NU-1:0][AW-1:0]        a_val,
    output logic [NU-1:0][AW-1:0]        a_msk,
    output logic [NU-1:0][DW-1:0]        d_val,
    output logic [NU-1:0][DW-1:0]        d_msk,
    output logic [NU-1:0][CTRL_W-1:0]    c_val,
    output logic [NU-1:0][CTRL_W-1:0]    c_msk,
    output logic [NU-1:0][CFG_W-1:0]     cfg
);

    localparam int FW = DW + RAW + 1;
    localparam int IW = 3;
    localparam int UW = RAW - IW;

    logic [FW-1:0] sr;
    logic [DW-1:0] payload;
    logic [UW-1:0] sel_unit;
    logic [IW-1:0] sel_idx;
    logic          is_write;
    logic [DW-1:0] rd_val;

    assign payload  = sr[DW-1:0];
    assign sel_idx  = sr[DW+IW-1:DW];
    assign sel_unit = sr[DW+RAW-1:DW+IW];
    assign is_write = sr[FW-1];
    assign sh_dout  = sr[0];

    // Readback selection for read frames
    always_comb begin
        rd_val = '0;
        for (int u = 0; u < NU; u++) begin
            if (int'(sel_unit) == u) begin
                case (sel_idx)
                    IDX_AVAL:  rd_val = DW'(a_val[u]);
                    IDX_AMASK: rd_val = DW'(a_msk[u]);
                    IDX_DVAL:  rd_val = d_val[u];
                    IDX_DMASK: rd_val = d_msk[u];
                    IDX_CVAL:  rd_val = DW'(c_val[u]);
                    IDX_CMASK: rd_val = DW'(c_msk[u]);
                    IDX_CFG:   rd_val = DW'(cfg[u]);
                    default:   rd_val = '0;
                endcase
            end
        end
    end

    // Frame shifter: update has priority over shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (sh_upd) begin
            if (!is_write) begin
                sr[DW-1:0] <= rd_val;
            end
        end else if (sh_en) begin
            sr <= {sh_din, sr[FW-1:1]};
        end
    end

    // Register file, written only on an update strobe of a write frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_val <= '0;
            a_msk <= '0;
            d_val <= '0;
            d_msk <= '0;
            c_val <= '0;
            c_msk <= '0;
            cfg   <= '0;
        end else if (sh_upd && is_write) begin
            for (int u = 0; u < NU; u++) begin
                if (int'(sel_unit) == u) begin
                    case (sel_idx)
                        IDX_AVAL:  a_val[u] <= payload[AW-1:0];
                        IDX_AMASK: a_msk[u] <= payload[AW-1:0];
                        IDX_DVAL:  d_val[u] <= payload;
                        IDX_DMASK: d_msk[u] <= payload;
                        IDX_CVAL:  c_val[u] <= payload[CTRL_W-1:0];
                        IDX_CMASK: c_msk[u] <= payload[CTRL_W-1:0];
                        IDX_CFG:   cfg[u]   <= payload[CFG_W-1:0];
                        default:   ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/wp_unit.sv
module wp_unit
    import wp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              en,
    input  logic              mode_fetch,
    input  logic [AW-1:0]     a_val,
    input  logic [AW-1:0]     a_msk,
    input  logic [DW-1:0]     d_val,
    input  logic [DW-1:0]     d_msk,
    input  logic [CTRL_W-1:0] c_val,
    input  logic [CTRL_W-1:0] c_msk,
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_data,
    input  logic [CTRL_W-1:0] bus_ctrl,
    output logic              hit
);

    logic addr_ok;
    logic data_ok;
    logic ctrl_ok;
    logic kind_ok;

    // A set mask bit removes that bit from the comparison
    assign addr_ok = ((bus_addr ^ a_val) & ~a_msk) == '0;
    assign data_ok = ((bus_data ^ d_val) & ~d_msk) == '0;
    assign ctrl_ok = ((bus_ctrl ^ c_val) & ~c_msk) == '0;
    assign kind_ok = (bus_fetch == mode_fetch);

    assign hit = en && bus_valid && kind_ok && addr_ok && data_ok && ctrl_ok;

endmodule

// File: rtl/wp_halt_fsm.sv
module wp_halt_fsm
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_hit,
    input  logic dbg_ack,
    output logic halt_req
);

    halt_st_t st_q;
    halt_st_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ARMED: if (any_hit)  st_d = ST_HALT;   // trigger
            ST_HALT:  if (dbg_ack)  st_d = ST_DEBUG;  // acknowledge
            ST_DEBUG: if (!dbg_ack) st_d = ST_ARMED;  // resume
            default:                st_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_ARMED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        halt_req = (st_q == ST_HALT);
    end

endmodule

// File: rtl/wp_top.sv
module wp_top
    import wp_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NU  = 2,
    parameter int RAW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sh_en,
    input  logic          sh_din,
    input  logic          sh_upd,
    output logic          sh_dout,
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [NU-1:0] ext_cond,
    input  logic          dbg_ack,
    output logic          halt_req,
    output logic [NU-1:0] unit_hit
);

    logic [NU-1:0][AW-1:0]     a_val;
    logic [NU-1:0][AW-1:0]     a_msk;
    logic [NU-1:0][DW-1:0]     d_val;
    logic [NU-1:0][DW-1:0]     d_msk;
    logic [NU-1:0][CTRL_W-1:0] c_val;
    logic [NU-1:0][CTRL_W-1:0] c_msk;
    logic [NU-1:0][CFG_W-1:0]  cfg;
    logic [NU-1:0]             cfg_en;
    logic [NU-1:0]             cfg_mode;

    wp_regs #(.AW(AW), .DW(DW), .NU(NU), .RAW(RAW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sh_en   (sh_en),
        .sh_din  (sh_din),
        .sh_upd  (sh_upd),
        .sh_dout (sh_dout),
        .a_val   (a_val),
        .a_msk   (a_msk),
        .d_val   (d_val),
        .d_msk   (d_msk),
        .c_val   (c_val),
        .c_msk   (c_msk),
        .cfg     (cfg)
    );

    for (genvar u = 0; u < NU; u++) begin : g_unit
        logic [CTRL_W-1:0] live_ctrl;

        assign cfg_en[u]   = cfg[u][0];
        assign cfg_mode[u] = cfg[u][1];
        assign live_ctrl   = {ext_cond[u], bus_size, bus_write};

        wp_unit #(.AW(AW), .DW(DW)) u_cmp (
            .en         (cfg_en[u]),
            .mode_fetch (cfg_mode[u]),
            .a_val      (a_val[u]),
            .a_msk      (a_msk[u]),
            .d_val      (d_val[u]),
            .d_msk      (d_msk[u]),
            .c_val      (c_val[u]),
            .c_msk      (c_msk[u]),
            .bus_valid  (bus_valid),
            .bus_fetch  (bus_fetch),
            .bus_addr   (bus_addr),
            .bus_data   (bus_data),
            .bus_ctrl   (live_ctrl),
            .hit        (unit_hit[u])
        );
    end

    wp_halt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_hit  (|unit_hit),
        .dbg_ack  (dbg_ack),
        .halt_req (halt_req)
    );

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
    parameter int NU = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sh_upd,
    input logic          bus_valid,
    input logic          bus_fetch,
    input logic          dbg_ack,
    input logic          halt_req,
    input logic [NU-1:0] unit_hit,
    input logic [NU-1:0] cfg_en,
    input logic [NU-1:0] cfg_mode
);

    assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(|unit_hit));

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !dbg_ack) |=> halt_req);

    assert_halt_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && dbg_ack) |=> !halt_req);

    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (unit_hit == '0));

    assert_cfg_only_on_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_upd |=> $stable(cfg_en) && $stable(cfg_mode));

    for (genvar u = 0; u < NU; u++) begin : g_chk
        assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[u] |-> !unit_hit[u]);

        assert_mode_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
            unit_hit[u] |-> (bus_fetch == cfg_mode[u]));
    end

endmodule

bind wp_top wp_checker #(.NU(NU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_upd    (sh_upd),
    .bus_valid (bus_valid),
    .bus_fetch (bus_fetch),
    .dbg_ack   (dbg_ack),
    .halt_req  (halt_req),
    .unit_hit  (unit_hit),
    .cfg_en    (cfg_en),
    .cfg_mode  (cfg_mode)
);

// File: tb/sim_wp_top.sv
`timescale 1ns/1ps
module sim_wp_top;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        sh_en = 0, sh_din = 0, sh_upd = 0;
    logic        sh_dout;
    logic        bus_valid = 0, bus_fetch = 0, bus_write = 0;
    logic [1:0]  bus_size = 0;
    logic [31:0] bus_addr = 0, bus_data = 0;
    logic [1:0]  ext_cond = 0;
    logic        dbg_ack = 0;
    logic        halt_req;
    logic [1:0]  unit_hit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wp_top u0 (
        .clk(clk), .rst_n(rst_n), .sh_en(sh_en), .sh_din(sh_din), .sh_upd(sh_upd),
        .sh_dout(sh_dout), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_data(bus_data), .ext_cond(ext_cond), .dbg_ack(dbg_ack),
        .halt_req(halt_req), .unit_hit(unit_hit)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_reg [0:31];
    bit          m_q [$];
    int          m_st = 0;   // 0 armed, 1 halt, 2 debug

    function automatic logic [31:0] width_mask(int idx);
        if (idx == 4 || idx == 5) return 32'hF;
        if (idx == 6) return 32'h3;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit ref_hit(int u);
        int b = u * 8;
        logic [3:0] live;
        if (!m_reg[b+6][0] || !bus_valid) return 0;
        if (bus_fetch != m_reg[b+6][1]) return 0;
        live = {ext_cond[u], bus_size, bus_write};
        for (int i = 0; i < 32; i++) begin
            if (!m_reg[b+1][i] && bus_addr[i] != m_reg[b][i]) return 0;
            if (!m_reg[b+3][i] && bus_data[i] != m_reg[b+2][i]) return 0;
        end
        for (int i = 0; i < 4; i++)
            if (!m_reg[b+5][i] && live[i] != m_reg[b+4][i]) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_reg[i] = 0;
            m_q.delete();
            m_st = 0;
        end else begin
            bit any;
            any = ref_hit(0) || ref_hit(1);
            case (m_st)
                0: if (any) m_st = 1;
                1: if (dbg_ack) m_st = 2;
                default: if (!dbg_ack) m_st = 0;
            endcase
            if (sh_upd) begin
                if (m_q.size() >= 38) begin
                    logic [37:0] fr;
                    int base;
                    base = m_q.size() - 38;
                    for (int i = 0; i < 38; i++) fr[i] = m_q[base + i];
                    if (fr[37] && fr[36:35] < 2 && fr[34:32] != 3'd7)
                        m_reg[fr[36:32]] = fr[31:0] & width_mask(fr[34:32]);
                end
            end else if (sh_en) begin
                m_q.push_back(sh_din);
                if (m_q.size() > 64) void'(m_q.pop_front());
            end
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] eh;
            eh = {ref_hit(1), ref_hit(0)};
            checks++;
            if (unit_hit !== eh) begin
                errors++;
                $display("FAIL R2 model unit_hit actual=%b expected=%b t=%0t", unit_hit, eh, $time);
            end
            checks++;
            if (halt_req !== (m_st == 1)) begin
                errors++;
                $display("FAIL R7 model halt_req actual=%b expected=%b t=%0t", halt_req, (m_st == 1), $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(bit rw, logic [4:0] a, logic [31:0] d, bit do_upd);
        logic [37:0] f = {rw, a, d};
        for (int i = 0; i < 38; i++) begin
            sh_din = f[i];
            sh_en  = 1;
            step(1);
        end
        sh_en = 0;
        sh_din = 0;
        if (do_upd) begin
            sh_upd = 1;
            step(1);
            sh_upd = 0;
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        send(1, a, d, 1);
    endtask

    task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
        logic [31:0] got;
        send(0, a, 32'h0, 1);
        sh_en = 1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            got[i] = sh_dout;
            step(1);
        end
        sh_en = 0;
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s readback addr=%0d actual=%h expected=%h", tag, a, got, exp);
        end
    endtask

    task automatic bus(bit v, bit f, bit w, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
        bus_valid = v; bus_fetch = f; bus_write = w;
        bus_size = sz; bus_addr = a; bus_data = d;
    endtask

    task automatic idle;
        bus(0, 0, 0, 2'd0, 32'h0, 32'h0);
    endtask

    task automatic chk_hit(logic [1:0] exp, string tag);
        @(negedge clk);
        checks++;
        if (unit_hit !== exp) begin
            errors++;
            $display("FAIL %s unit_hit actual=%b expected=%b", tag, unit_hit, exp);
        end
        step(1);
    endtask

    task automatic chk_halt(bit exp, string tag);
        @(negedge clk);
        checks++;
        if (halt_req !== exp) begin
            errors++;
            $display("FAIL %s halt_req actual=%b expected=%b", tag, halt_req, exp);
        end
        step(1);
    endtask

    task automatic release_halt;
        idle();
        dbg_ack = 1;
        step(2);
        dbg_ack = 0;
        step(2);
    endtask

    // ---------------- directed stimulus ----------------
    initial begin
        step(3);
        rst_n = 1;
        step(1);

        // R1: reset state
        chk_halt(0, "R1");
        chk_hit(2'b00, "R1");
        rd_chk(5'd6, 32'h0, "R1");
        rd_chk(5'd2, 32'h0, "R1");

        // Unit 0: data watchpoint, write of size 2, ext ignored
        wr(5'd0, 32'h0000_1000);
        wr(5'd1, 32'h0);
        wr(5'd2, 32'hDEAD_BEEF);
        wr(5'd3, 32'h0);
        wr(5'd4, 32'h5);
        wr(5'd5, 32'h8);
        wr(5'd6, 32'h1);

        // R2 + R7: hit, request, hold, acknowledge, ignore while debugging, resume
        bus(1, 0, 1, 2'd2, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b01, "R2");
        idle();
        chk_halt(1, "R7");
        chk_halt(1, "R7");
        dbg_ack = 1;
        chk_halt(1, "R7");
        chk_halt(0, "R7");
        bus(1, 0, 1, 2'd2, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b01, "R7");
        idle();
        chk_halt(0, "R7");
        dbg_ack = 0;
        step(1);
        chk_halt(0, "R7");

        // R9: read access or wrong size fails the control compare
        bus(1, 0, 0, 2'd2, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b00, "R9");
        bus(1, 0, 1, 2'd1, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b00, "R9");
        idle();

        // R3: one address bit off misses; masking that bit makes it hit
        bus(1, 0, 1, 2'd2, 32'h0000_1010, 32'hDEAD_BEEF);
        chk_hit(2'b00, "R3");
        idle();
        wr(5'd1, 32'h0000_0010);
        bus(1, 0, 1, 2'd2, 32'h0000_1010, 32'hDEAD_BEEF);
        chk_hit(2'b01, "R3");
        release_halt();

        // R4: a fetch does not satisfy a data watchpoint
        bus(1, 1, 1, 2'd2, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b00, "R4");
        idle();
        wr(5'd6, 32'h3);
        bus(1, 1, 1, 2'd2, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b01, "R4");
        bus(1, 0, 1, 2'd2, 32'h0000_1000, 32'hDEAD_BEEF);
        chk_hit(2'b00, "R4");
        release_halt();

        // R5: breakpoint is data dependent
        bus(1, 1, 1, 2'd2, 32'h0000_1000, 32'hDEAD_BEEE);
        chk_hit(2'b00, "R5");
        idle();
        wr(5'd3, 32'hFFFF_FFFF);
        bus(1, 1, 1, 2'd2, 32'h0000_1000, 32'h1234_5678);
        chk_hit(2'b01, "R5");
        release_halt();

        // R6: disabled unit stays silent and raises no halt
        wr(5'd6, 32'h2);
        bus(1, 1, 1, 2'd2, 32'h0000_1000, 32'h1234_5678);
        chk_hit(2'b00, "R6");
        idle();
        chk_halt(0, "R6");

        // R9: unit 1 qualifies only on its own condition line
        wr(5'd9, 32'hFFFF_FFFF);
        wr(5'd11, 32'hFFFF_FFFF);
        wr(5'd12, 32'h8);
        wr(5'd13, 32'h7);
        wr(5'd14, 32'h1);
        ext_cond = 2'b01;
        bus(1, 0, 0, 2'd0, 32'hABCD_0000, 32'h0);
        chk_hit(2'b00, "R9");
        ext_cond = 2'b10;
        chk_hit(2'b10, "R9");
        release_halt();

        // R11: both units hit together
        wr(5'd6, 32'h1);
        wr(5'd1, 32'hFFFF_FFFF);
        wr(5'd5, 32'hF);
        bus(1, 0, 1, 2'd3, 32'h7777_7777, 32'h0);
        chk_hit(2'b11, "R11");
        idle();
        chk_halt(1, "R11");
        release_halt();

        // R8: a shifted frame without update strobe changes nothing
        send(1, 5'd6, 32'h0, 0);
        step(2);
        bus(1, 0, 1, 2'd3, 32'h7777_7777, 32'h0);
        chk_hit(2'b11, "R8");
        release_halt();
        ext_cond = 2'b00;

        // R10: readback of mapped registers and unmapped slots
        rd_chk(5'd13, 32'h7, "R10");
        rd_chk(5'd0, 32'h0000_1000, "R10");
        wr(5'd7, 32'hFFFF_FFFF);
        rd_chk(5'd7, 32'h0, "R10");
        wr(5'd16, 32'h1234_5678);
        rd_chk(5'd16, 32'h0, "R10");
        rd_chk(5'd6, 32'h1, "R10");

        step(3);
        report();
        $finish;
    end

endmodule